// File: doc/BRIEF.md
# IO translation unit register file

This block is the software-visible register file of an IO address translation unit. A processor-side register bus performs 32-bit word reads and writes at a word offset, and each access reaches one of the following: the unit's control word, the page-table base, two flush words, the fault status and fault address, the arbiter enable word, four per-slot configuration words, the arbitration enable word and a mask identification word. Each register applies its own write mask and its own forced bits. The flush words only hold what was written; no flush action takes place here.

The range field of the control word picks the size of a power-of-two translation window. Every window ends at 0xFFFFFFFF. The block decodes the field into a registered window start address and exports it, together with the page-table base, to the translation logic. That logic reports a fault through a side port, which loads the fault status and fault address and raises a level interrupt. The interrupt drops when the bus reads or writes either fault register. Offsets that hold no implemented register are backed by a small scratch array, so they read back what was last written to them.

Top module: `iox_regfile`

## Requirements
- R1: After reset the registers read as follows: control = VERSION in bits [31:24] with all other bits 0; base, both flush words, fault address and the four slot words = 0; fault status = 0x00800000; arbiter enable = 0x00000003; arbitration enable = 0x00000008; mask ID = 0x23000000. After reset, win_start = 0 and irq = 0.
- R2: A write to the control word (word offset 0x000) keeps the written bits under mask 0x0000001D, and VERSION is placed in bits [31:24]. A read returns that value in the same cycle as the request.
- R3: A control write with range code c in bits [4:2] loads win_start with 2^32 - 2^(24+c), so code 0 gives 0xFF000000 and code 7 gives 0x80000000. win_start changes on no other event.
- R4: A write to the base word (offset 0x001) keeps only the bits under mask 0x07FFFC00, and tbl_base shows the stored value. The full flush word (offset 0x005) and the page flush word (offset 0x006) store all 32 bits.
- R5: A write to arbiter enable (offset 0x402) keeps mask 0x801F000F and forces bit 0 to 1. A write to arbitration enable (offset 0x800) keeps mask 0x001F0000 and forces 0x8.
- R6: A write to fault status (offset 0x400) keeps mask 0xFF0FFFFF and forces bit 23 to 1. A write to fault address (offset 0x401) stores all 32 bits.
- R7: The four slot configuration words at offsets 0x404 to 0x407 each keep only mask 0x00010003, and each is stored independently of the other three.
- R8: A write to mask ID (offset 0xC06) ORs the written value under mask 0x00FFFFFF into the current contents. Bits that are already set never clear.
- R9: A pulse on flt_load stores flt_status (with bit 23 forced to 1) into fault status and flt_addr into fault address, and raises irq in the next cycle. If a bus write to a fault register happens in the same cycle, the load wins and irq stays high.
- R10: A bus read or write of offset 0x400 or 0x401 drops irq in the next cycle. An access to any other offset leaves irq unchanged.
- R11: A write to an offset with no implemented register goes to scratch entry offset mod SCRATCH_DEPTH. A read of such an offset returns that entry, and implemented registers are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_off | input | 12 | Word offset (byte offset shifted right by 2) |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data for the current request offset |
| flt_load | input | 1 | Fault report from the translation logic |
| flt_status | input | 32 | Fault status value to load |
| flt_addr | input | 32 | Fault address value to load |
| win_start | output | 32 | Start address of the translation window |
| tbl_base | output | 32 | Page-table base register |
| irq | output | 1 | Level fault interrupt |

## Verification
The bench builds the block with VERSION = 0xA5, which differs from the default of 0. This shows that the version byte is applied both at reset and on every control write. It keeps SCRATCH_DEPTH = 8, so offsets 0x123 and 0x30B share scratch entry 3 while 0x0A0 uses entry 0; this makes the aliasing and the isolation of the scratch entries observable. All eight range codes are swept, and the fault-load priority is tested with a bus write to the fault status in the same cycle as the load.

// File: rtl/iox_pkg.sv
package iox_pkg;
    parameter int OFF_W  = 12;
    parameter int DATA_W = 32;
    parameter int SLOTS  = 4;

    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [DATA_W-1:0] word_t;

    localparam off_t OFF_CTRL   = 12'h000;
    localparam off_t OFF_BASE   = 12'h001;
    localparam off_t OFF_FLALL  = 12'h005;
    localparam off_t OFF_FLPG   = 12'h006;
    localparam off_t OFF_FSTAT  = 12'h400;
    localparam off_t OFF_FADDR  = 12'h401;
    localparam off_t OFF_ARBMSK = 12'h402;
    localparam off_t OFF_SLOT0  = 12'h404;
    localparam off_t OFF_ARBON  = 12'h800;
    localparam off_t OFF_MASKID = 12'h C06;

    localparam word_t M_CTRL   = 32'h0000_001D;
    localparam word_t M_BASE   = 32'h07FF_FC00;
    localparam word_t M_FSTAT  = 32'hFF0F_FFFF;
    localparam word_t F_FSTAT  = 32'h0080_0000;
    localparam word_t M_ARBMSK = 32'h801F_000F;
    localparam word_t F_ARBMSK = 32'h0000_0001;
    localparam word_t R_ARBMSK = 32'h0000_0003;
    localparam word_t M_SLOT   = 32'h0001_0003;
    localparam word_t M_ARBON  = 32'h001F_0000;
    localparam word_t F_ARBON  = 32'h0000_0008;
    localparam word_t M_MASKID = 32'h00FF_FFFF;
    localparam word_t R_MASKID = 32'h2300_0000;

    localparam int RNG_LSB = 2;
    localparam int RNG_W   = 3;
    localparam int VER_LSB = 24;

    typedef struct packed {
        word_t                  ctrl;
        word_t                  base;
        word_t                  fl_all;
        word_t                  fl_pg;
        word_t                  fstat;
        word_t                  faddr;
        word_t                  arbmsk;
        logic [SLOTS-1:0][DATA_W-1:0] slot;
        word_t                  arbon;
        word_t                  maskid;
        word_t                  win;
        logic                   irq;
    } regs_t;
endpackage

// File: rtl/iox_win_dec.sv
module iox_win_dec #(
    parameter int CODE_W   = 3,
    parameter int ADDR_W   = 32,
    parameter int MIN_LOG2 = 24
) (
    input  logic [CODE_W-1:0] code,
    output logic [ADDR_W-1:0] start
);
    localparam int NCODES = 2 ** CODE_W;

    logic [ADDR_W-1:0] tbl [NCODES];

    for (genvar g = 0; g < NCODES; g++) begin : g_win
        assign tbl[g] = {ADDR_W{1'b1}} << (MIN_LOG2 + g);
    end

    assign start = tbl[code];

    always_comb begin
        a_r3_start_aligned : assert (start[MIN_LOG2-1:0] == '0);
    end
endmodule

// File: rtl/iox_scratch.sv
module iox_scratch #(
    parameter int DEPTH = 8,
    parameter int DW    = 32,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we) begin
            mem_d[idx] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rdata = mem_q[idx];

    a_r11_write_lands : assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem_q[$past(idx)] == $past(wdata));
endmodule

// File: rtl/iox_regfile.sv
module iox_regfile
    import iox_pkg::*;
#(
    parameter logic [7:0] VERSION       = 8'h00,
    parameter int         SCRATCH_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              flt_load,
    input  logic [DATA_W-1:0] flt_status,
    input  logic [DATA_W-1:0] flt_addr,
    output logic [DATA_W-1:0] win_start,
    output logic [DATA_W-1:0] tbl_base,
    output logic              irq
);
    localparam int    SCR_IDX_W = (SCRATCH_DEPTH > 1) ? $clog2(SCRATCH_DEPTH) : 1;
    localparam int    SLOT_IW   = $clog2(SLOTS);
    localparam word_t VER_WORD  = word_t'(VERSION) << VER_LSB;

    regs_t r_q, r_d;

    logic          wr_en, rd_en, fault_hit, slot_hit, impl_hit, scr_we;
    logic [SLOT_IW-1:0] slot_idx;
    word_t         dec_start, scr_rdata;

    iox_win_dec #(
        .CODE_W  (RNG_W),
        .ADDR_W  (DATA_W),
        .MIN_LOG2(24)
    ) u_win (
        .code (req_wdata[RNG_LSB +: RNG_W]),
        .start(dec_start)
    );

    iox_scratch #(
        .DEPTH(SCRATCH_DEPTH),
        .DW   (DATA_W)
    ) u_scr (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (scr_we),
        .idx  (req_off[SCR_IDX_W-1:0]),
        .wdata(req_wdata),
        .rdata(scr_rdata)
    );

    always_comb begin
        wr_en     = req_valid & req_write;
        rd_en     = req_valid & ~req_write;
        fault_hit = req_valid & ((req_off == OFF_FSTAT) | (req_off == OFF_FADDR));
        slot_hit  = (req_off[OFF_W-1:SLOT_IW] == OFF_SLOT0[OFF_W-1:SLOT_IW]);
        slot_idx  = req_off[SLOT_IW-1:0];
        impl_hit  = slot_hit
                  | (req_off == OFF_CTRL)   | (req_off == OFF_BASE)
                  | (req_off == OFF_FLALL)  | (req_off == OFF_FLPG)
                  | (req_off == OFF_FSTAT)  | (req_off == OFF_FADDR)
                  | (req_off == OFF_ARBMSK) | (req_off == OFF_ARBON)
                  | (req_off == OFF_MASKID);
        scr_we    = wr_en & ~impl_hit;

        r_d = r_q;
        if (wr_en) begin
            if (slot_hit) begin
                r_d.slot[slot_idx] = req_wdata & M_SLOT;
            end
            unique case (req_off)
                OFF_CTRL: begin
                    r_d.ctrl = (req_wdata & M_CTRL) | VER_WORD;
                    r_d.win  = dec_start;
                end
                OFF_BASE:   r_d.base   = req_wdata & M_BASE;
                OFF_FLALL:  r_d.fl_all = req_wdata;
                OFF_FLPG:   r_d.fl_pg  = req_wdata;
                OFF_FSTAT:  r_d.fstat  = (req_wdata & M_FSTAT) | F_FSTAT;
                OFF_FADDR:  r_d.faddr  = req_wdata;
                OFF_ARBMSK: r_d.arbmsk = (req_wdata & M_ARBMSK) | F_ARBMSK;
                OFF_ARBON:  r_d.arbon  = (req_wdata & M_ARBON) | F_ARBON;
                OFF_MASKID: r_d.maskid = r_q.maskid | (req_wdata & M_MASKID);
                default: ;
            endcase
        end
        if (fault_hit) begin
            r_d.irq = 1'b0;
        end
        if (flt_load) begin
            r_d.fstat = flt_status | F_FSTAT;
            r_d.faddr = flt_addr;
            r_d.irq   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.ctrl   <= VER_WORD;
            r_q.fstat  <= F_FSTAT;
            r_q.arbmsk <= R_ARBMSK;
            r_q.arbon  <= F_ARBON;
            r_q.maskid <= R_MASKID;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rsp_rdata = scr_rdata;
        if (slot_hit) begin
            rsp_rdata = r_q.slot[slot_idx];
        end
        unique case (req_off)
            OFF_CTRL:   rsp_rdata = r_q.ctrl;
            OFF_BASE:   rsp_rdata = r_q.base;
            OFF_FLALL:  rsp_rdata = r_q.fl_all;
            OFF_FLPG:   rsp_rdata = r_q.fl_pg;
            OFF_FSTAT:  rsp_rdata = r_q.fstat;
            OFF_FADDR:  rsp_rdata = r_q.faddr;
            OFF_ARBMSK: rsp_rdata = r_q.arbmsk;
            OFF_ARBON:  rsp_rdata = r_q.arbon;
            OFF_MASKID: rsp_rdata = r_q.maskid;
            default: ;
        endcase
    end

    assign win_start = r_q.win;
    assign tbl_base  = r_q.base;
    assign irq       = r_q.irq;

    a_r9_load_raises_irq : assert property (@(posedge clk) disable iff (!rst_n)
        flt_load |=> irq);

    a_r9_load_sets_addr : assert property (@(posedge clk) disable iff (!rst_n)
        flt_load |=> r_q.faddr == $past(flt_addr));

    a_r10_access_drops_irq : assert property (@(posedge clk) disable iff (!rst_n)
        (fault_hit && !flt_load) |=> !irq);

    a_r10_other_keeps_irq : assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_hit && !flt_load) |=> $stable(irq));

    a_r3_win_holds : assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && req_off == OFF_CTRL) |=> $stable(win_start));

    a_r8_maskid_sticky : assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (r_q.maskid & $past(r_q.maskid)) == $past(r_q.maskid));

    a_r4_base_holds : assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && req_off == OFF_BASE) |=> $stable(tbl_base));

    always_comb begin
        if (rd_en) begin
            a_r2_rd_known : assert (!$isunknown(rsp_rdata));
        end
    end
endmodule

// File: tb/iox_regfile_tb_top.sv
module iox_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_off = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        flt_load = 1'b0;
    logic [31:0] flt_status = '0;
    logic [31:0] flt_addr = '0;
    logic [31:0] win_start, tbl_base;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    iox_regfile #(.VERSION(8'hA5), .SCRATCH_DEPTH(8)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_off(req_off),
        .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .flt_load(flt_load), .flt_status(flt_status), .flt_addr(flt_addr),
        .win_start(win_start), .tbl_base(tbl_base), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // monitor: compares read data against the scoreboard queue
    always @(negedge clk) begin
        if (req_valid && !req_write) begin
            if (exp_q.size() == 0) begin
                chk("monitor empty queue", 32'd1, 32'd0);
            end else begin
                chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic bus_wr(input logic [11:0] off, input logic [31:0] d);
        @(posedge clk); #1;
        req_valid = 1; req_write = 1; req_off = off; req_wdata = d;
        @(posedge clk); #1;
        req_valid = 0; req_write = 0;
    endtask

    task automatic bus_rd(input logic [11:0] off, input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        exp_q.push_back(e); tag_q.push_back(tag);
        req_valid = 1; req_write = 0; req_off = off;
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    task automatic fault(input logic [31:0] st, input logic [31:0] ad);
        @(posedge clk); #1;
        flt_load = 1; flt_status = st; flt_addr = ad;
        @(posedge clk); #1;
        flt_load = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk("watchdog", 32'd1, 32'd0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset values
        chk("R1 win", win_start, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'h0);
        chk("R1 base", tbl_base, 32'h0);
        bus_rd(12'h000, 32'hA500_0000, "R1 ctrl");
        bus_rd(12'h400, 32'h0080_0000, "R1 fstat");
        bus_rd(12'h402, 32'h0000_0003, "R1 arbmsk");
        bus_rd(12'h800, 32'h0000_0008, "R1 arbon");
        bus_rd(12'hC06, 32'h2300_0000, "R1 maskid");
        bus_rd(12'h405, 32'h0, "R1 slot");
        bus_rd(12'h005, 32'h0, "R1 flush");

        // R2 control mask and version
        bus_wr(12'h000, 32'hFFFF_FFFF);
        bus_rd(12'h000, 32'hA500_001D, "R2 ctrl all ones");
        chk("R3 code7 win", win_start, 32'h8000_0000);

        // R3 every range code
        for (int c = 0; c < 8; c++) begin
            bus_wr(12'h000, (32'(c) << 2) | 32'h1);
            chk("R3 win sweep", win_start, 32'hFFFF_FFFF << (24 + c));
            bus_rd(12'h000, 32'hA500_0000 | (32'(c) << 2) | 32'h1, "R2 ctrl code");
        end
        bus_wr(12'h001, 32'h0000_0010);
        chk("R3 win held on other write", win_start, 32'h8000_0000);

        // R4 base and flushes
        bus_wr(12'h001, 32'hFFFF_FFFF);
        chk("R4 tbl_base", tbl_base, 32'h07FF_FC00);
        bus_rd(12'h001, 32'h07FF_FC00, "R4 base read");
        bus_wr(12'h005, 32'hDEAD_BEEF);
        bus_wr(12'h006, 32'h1234_5678);
        bus_rd(12'h005, 32'hDEAD_BEEF, "R4 full flush");
        bus_rd(12'h006, 32'h1234_5678, "R4 page flush");

        // R5 arbiter words
        bus_wr(12'h402, 32'h0);
        bus_rd(12'h402, 32'h0000_0001, "R5 arbmsk zero");
        bus_wr(12'h402, 32'hFFFF_FFFF);
        bus_rd(12'h402, 32'h801F_000F, "R5 arbmsk ones");
        bus_wr(12'h800, 32'h0);
        bus_rd(12'h800, 32'h0000_0008, "R5 arbon zero");
        bus_wr(12'h800, 32'hFFFF_FFFF);
        bus_rd(12'h800, 32'h001F_0008, "R5 arbon ones");

        // R6 fault registers by bus
        bus_wr(12'h400, 32'hFFFF_FFFF);
        bus_rd(12'h400, 32'hFF8F_FFFF, "R6 fstat ones");
        bus_wr(12'h400, 32'h0);
        bus_rd(12'h400, 32'h0080_0000, "R6 fstat zero");
        bus_wr(12'h401, 32'hCAFE_F00D);
        bus_rd(12'h401, 32'hCAFE_F00D, "R6 faddr");

        // R7 slot words
        for (int s = 0; s < 4; s++) bus_wr(12'h404 + 12'(s), 32'hFFFF_0000 | 32'(s));
        for (int s = 0; s < 4; s++) bus_rd(12'h404 + 12'(s), 32'h0001_0000 | 32'(s), "R7 slot");

        // R8 mask ID accumulates
        bus_wr(12'hC06, 32'h0000_00F0);
        bus_rd(12'hC06, 32'h2300_00F0, "R8 maskid or");
        bus_wr(12'hC06, 32'hFF00_000F);
        bus_rd(12'hC06, 32'h2300_00FF, "R8 maskid accumulate");

        // R9 and R10 fault port and interrupt clearing
        fault(32'h4000_0000, 32'h00AB_C000);
        chk("R9 irq raised", {31'd0, irq}, 32'h1);
        bus_rd(12'h001, 32'h07FF_FC00, "R10 other read");
        chk("R10 irq kept", {31'd0, irq}, 32'h1);
        bus_wr(12'h006, 32'h0);
        chk("R10 irq kept on write", {31'd0, irq}, 32'h1);
        bus_rd(12'h401, 32'h00AB_C000, "R9 faddr loaded");
        chk("R10 read clears irq", {31'd0, irq}, 32'h0);
        bus_rd(12'h400, 32'h4080_0000, "R9 fstat loaded");
        fault(32'h0, 32'h1);
        bus_wr(12'h400, 32'h0);
        chk("R10 write fstat clears irq", {31'd0, irq}, 32'h0);
        fault(32'h0, 32'h2);
        bus_wr(12'h401, 32'h0);
        chk("R10 write faddr clears irq", {31'd0, irq}, 32'h0);

        // R9 priority over simultaneous bus write
        @(posedge clk); #1;
        flt_load = 1; flt_status = 32'h1000_0000; flt_addr = 32'h0000_7000;
        req_valid = 1; req_write = 1; req_off = 12'h400; req_wdata = 32'h0;
        @(posedge clk); #1;
        flt_load = 0; req_valid = 0; req_write = 0;
        chk("R9 load wins irq", {31'd0, irq}, 32'h1);
        bus_rd(12'h400, 32'h1080_0000, "R9 load wins fstat");

        // R11 scratch offsets
        bus_wr(12'h123, 32'h1111_1111);
        bus_wr(12'h0A0, 32'h2222_2222);
        bus_rd(12'h123, 32'h1111_1111, "R11 scratch entry 3");
        bus_rd(12'h0A0, 32'h2222_2222, "R11 scratch entry 0");
        bus_rd(12'h30B, 32'h1111_1111, "R11 scratch alias");
        bus_rd(12'h000, 32'hA500_001D, "R11 ctrl untouched");
        chk("R11 base untouched", tbl_base, 32'h07FF_FC00);

        repeat (2) @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule